// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block takes a logical address, given as a segment-register id and an offset, and returns a linear address. A per-request mode input picks one of two paths.

The legacy path shifts the 16-bit segment value left by four bits and adds the low 16 bits of the offset. The result is 20 bits wide.

The protected path treats the chosen segment register as a selector. The selector picks an entry from a small on-chip descriptor table. The block takes a 32-bit base and a 20-bit limit from that 64-bit entry, checks the offset against the limit, and adds the base to the offset.

Software loads the six segment registers and the descriptor entries through two write ports. Requests enter through a valid/ready port and return one cycle later on a valid/ready response port. Each response carries the address and a fault code. Any fault forces the address to zero.

Top module: `seg_xlate`

## Requirements
- R1: In legacy mode (mode input 0), the result is ({segment value, 4'b0000} + offset[15:0]) modulo 2^20, zero-extended to 32 bits. Fault code 0 (none) is returned. Offset bits [31:16] are ignored.
- R2: Segment registers 0 to 5 are written through the segment write port. Ids 6 and 7 read as zero, and writes to them are ignored.
- R3: In protected mode (mode input 1), selector bits [15:3] form the table index, bit 2 is the table indicator, and bits [1:0] are ignored. The descriptor base is {d[63:56], d[39:16]} and the limit is {d[51:48], d[15:0]}. The result is (base + offset) modulo 2^32.
- R4: A protected request whose selector has indicator 0 and index 0 returns fault code 2 (null) and address 0.
- R5: A protected request whose selector has indicator 1 returns fault code 1. This fault takes priority over every other fault.
- R6: A protected request whose index is 16 or more (beyond the table) returns fault code 3 and address 0.
- R7: A protected request whose descriptor has bit 47 (present) at 0 returns fault code 4 and address 0.
- R8: The effective limit is the 20-bit limit when descriptor bit 55 is 0, and {limit, 12'hFFF} when bit 55 is 1. An offset greater than the effective limit returns fault code 5 and address 0. An offset equal to the effective limit translates normally.
- R9: A descriptor with base 0, limit 20'hFFFFF and bit 55 set returns the offset unchanged for every offset, including 0 and 32'hFFFFFFFF.
- R10: A request is accepted when req_valid_i and req_ready_o are both high. Its response is valid on the next cycle. While rsp_valid_o is high and rsp_ready_i is low, the response stays stable and req_ready_o is low.
- R11: A segment-register or descriptor write made in the same cycle as an accepted request does not affect that request. It affects the next request.
- R12: After reset, rsp_valid_o is low, req_ready_o is high, and all segment registers and descriptors are zero, so a protected request returns the null fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sreg_we_i | input | 1 | Segment register write enable |
| sreg_id_i | input | 3 | Segment register written |
| sreg_data_i | input | 16 | Segment value or selector written |
| desc_we_i | input | 1 | Descriptor write enable |
| desc_idx_i | input | 4 | Descriptor slot written |
| desc_data_i | input | 64 | Descriptor contents |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_mode_i | input | 1 | 0 legacy, 1 protected |
| req_seg_i | input | 3 | Segment register used |
| req_off_i | input | 32 | Offset |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_addr_o | output | 32 | Linear address, zero on fault |
| rsp_fault_o | output | 3 | Fault code: 0 none, 1 indicator, 2 null, 3 range, 4 absent, 5 limit |

## Verification
The bench targets a set of corner cases, each of which exposes a specific kind of design error:
- Legacy carry out of bit 19. A design that kept the carry would return a 21-bit address.
- An offset exactly equal to the limit, and one just past it. Either an off-by-one in the compare or a missing granularity scaling shows up here.
- A base that wraps to zero at the top of the 4 GB range.
- A selector with its privilege bits set. A design that did not mask them would index the wrong slot.
- The fault ordering among the indicator, null, range and absent faults.
- A write landing in the same cycle as a request. A design that forwarded the write would change that request's result.
- Back-pressure. A design that overwrote or dropped a held response would show a changed address while rsp_ready_i is low.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TI     = 3'd1,
    FLT_NULL   = 3'd2,
    FLT_RANGE  = 3'd3,
    FLT_ABSENT = 3'd4,
    FLT_LIMIT  = 3'd5
  } flt_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        present;
  } desc_t;

  function automatic desc_t unpack_desc(logic [63:0] d);
    desc_t r;
    r.base    = {d[63:56], d[39:16]};
    r.limit   = {d[51:48], d[15:0]};
    r.gran    = d[55];
    r.present = d[47];
    return r;
  endfunction
endpackage

// File: rtl/seg_sel_regs.sv
module seg_sel_regs #(
  parameter int NSEG  = 6,
  parameter int IDW   = 3,
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDW-1:0]   wid_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IDW-1:0]   rid_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [NSEG-1:0][WIDTH-1:0] regs_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && wid_i == IDW'(g))       regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSEG; i++)
      if (rid_i == IDW'(i)) rdata_o = regs_q[i];
  end

  AST_UNUSED_ID_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(wid_i) >= NSEG) |=> $stable(regs_q)); // R2
endmodule

// File: rtl/seg_desc_store.sv
module seg_desc_store #(
  parameter int ENTRIES = 16,
  parameter int IDXW    = $clog2(ENTRIES),
  parameter int DW      = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [IDXW-1:0] ridx_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && widx_i == IDXW'(g))  mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/seg_xlate_core.sv
module seg_xlate_core
  import seg_xlate_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        prot_i,
  input  logic [15:0] sel_i,
  input  logic [31:0] off_i,
  input  logic [63:0] desc_i,
  output logic [31:0] addr_o,
  output flt_e        fault_o
);
  localparam logic [12:0] NENT = 13'(ENTRIES);

  desc_t       d;
  logic [12:0] idx;
  logic        ti;
  logic [31:0] eff_lim;
  logic [19:0] real_sum;

  assign d        = unpack_desc(desc_i);
  assign idx      = sel_i[15:3];
  assign ti       = sel_i[2];
  assign eff_lim  = d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
  assign real_sum = {sel_i, 4'h0} + {4'h0, off_i[15:0]};

  // fault priority: indicator, null, range, absent, limit
  always_comb begin
    fault_o = FLT_NONE;
    addr_o  = '0;
    if (!prot_i)                addr_o  = {12'h000, real_sum};
    else if (ti)                fault_o = FLT_TI;
    else if (idx == '0)         fault_o = FLT_NULL;
    else if (idx >= NENT)       fault_o = FLT_RANGE;
    else if (!d.present)        fault_o = FLT_ABSENT;
    else if (off_i > eff_lim)   fault_o = FLT_LIMIT;
    else                        addr_o  = d.base + off_i;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG    = 6,
  parameter int ENTRIES = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sreg_we_i,
  input  logic [2:0]                 sreg_id_i,
  input  logic [15:0]                sreg_data_i,
  input  logic                       desc_we_i,
  input  logic [$clog2(ENTRIES)-1:0] desc_idx_i,
  input  logic [63:0]                desc_data_i,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_mode_i,
  input  logic [2:0]                 req_seg_i,
  input  logic [31:0]                req_off_i,
  output logic                       rsp_valid_o,
  input  logic                       rsp_ready_i,
  output logic [31:0]                rsp_addr_o,
  output logic [2:0]                 rsp_fault_o
);
  localparam int IDXW = $clog2(ENTRIES);

  logic [15:0] sel;
  logic [63:0] desc;
  logic [31:0] xl_addr;
  flt_e        xl_fault;
  flt_e        fault_q;
  logic        accept;

  seg_sel_regs #(.NSEG(NSEG), .IDW(3), .WIDTH(16)) u_sregs (
    .clk_i, .rst_ni,
    .we_i(sreg_we_i), .wid_i(sreg_id_i), .wdata_i(sreg_data_i),
    .rid_i(req_seg_i), .rdata_o(sel)
  );

  seg_desc_store #(.ENTRIES(ENTRIES), .IDXW(IDXW), .DW(64)) u_desc (
    .clk_i, .rst_ni,
    .we_i(desc_we_i), .widx_i(desc_idx_i), .wdata_i(desc_data_i),
    .ridx_i(sel[3 +: IDXW]), .rdata_o(desc)
  );

  seg_xlate_core #(.ENTRIES(ENTRIES)) u_core (
    .prot_i(req_mode_i), .sel_i(sel), .off_i(req_off_i), .desc_i(desc),
    .addr_o(xl_addr), .fault_o(xl_fault)
  );

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  // reads use pre-edge state, so same-cycle writes land after this request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      fault_q     <= FLT_NONE;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_addr_o  <= xl_addr;
      fault_q     <= xl_fault;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  assign rsp_fault_o = fault_q;

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o); // R10
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_fault_o))); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> rsp_addr_o == 32'd0); // R8
  AST_REAL_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_mode_i) |=> (rsp_addr_o[31:20] == 12'd0 && rsp_fault_o == 3'd0)); // R1
  AST_NULL_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_mode_i && sel[15:2] == 14'd0) |=> rsp_fault_o == 3'd2); // R4
  AST_TI_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_mode_i && sel[2]) |=> rsp_fault_o == 3'd1); // R5
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sreg_we = 1'b0;
  logic [2:0]  sreg_id = '0;
  logic [15:0] sreg_data = '0;
  logic        desc_we = 1'b0;
  logic [3:0]  desc_idx = '0;
  logic [63:0] desc_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_mode = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [31:0] req_off = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_fault;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  seg_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sreg_we_i(sreg_we), .sreg_id_i(sreg_id), .sreg_data_i(sreg_data),
    .desc_we_i(desc_we), .desc_idx_i(desc_idx), .desc_data_i(desc_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_mode_i(req_mode),
    .req_seg_i(req_seg), .req_off_i(req_off),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault)
  );

  typedef struct packed {
    logic        mode;
    logic [2:0]  seg;
    logic [31:0] off;
    logic [31:0] addr;
    logic [2:0]  flt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'hFFFF_1234, 32'h0000_12E4, 3'd0, 4'd1},  // R1 upper offset ignored
    '{1'b0, 3'd5, 32'h0000_FFFF, 32'h0001_07FF, 3'd0, 4'd1},  // R1
    '{1'b0, 3'd6, 32'h0000_ABCD, 32'h0000_ABCD, 3'd0, 4'd2},  // R2 id 6 reads zero
    '{1'b1, 3'd0, 32'h0000_0010, 32'h1234_5688, 3'd0, 4'd3},  // R3 rpl bits ignored
    '{1'b1, 3'd0, 32'h0000_0FFF, 32'h1234_6677, 3'd0, 4'd8},  // R8 at limit
    '{1'b1, 3'd0, 32'h0000_1000, 32'h0000_0000, 3'd5, 4'd8},  // R8 past limit
    '{1'b1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd0, 4'd9},  // R9
    '{1'b1, 3'd1, 32'h0000_0000, 32'h0000_0000, 3'd0, 4'd9},  // R9
    '{1'b1, 3'd2, 32'h0000_1000, 32'h0000_0000, 3'd0, 4'd3},  // R3 wrap
    '{1'b1, 3'd3, 32'h0000_0000, 32'h0000_0000, 3'd4, 4'd7},  // R7
    '{1'b1, 3'd4, 32'h0000_0000, 32'h0000_0000, 3'd1, 4'd5},  // R5
    '{1'b1, 3'd5, 32'h0000_0000, 32'h0000_0000, 3'd3, 4'd6},  // R6
    '{1'b1, 3'd6, 32'h0000_0000, 32'h0000_0000, 3'd2, 4'd4}   // R4 via R2 zero id
  };

  function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] lim, logic g, logic p);
    logic [63:0] d = '0;
    d[63:56] = base[31:24];
    d[39:16] = base[23:0];
    d[51:48] = lim[19:16];
    d[15:0]  = lim[15:0];
    d[55]    = g;
    d[47]    = p;
    return d;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_sreg(logic [2:0] id, logic [15:0] v);
    sreg_we = 1'b1; sreg_id = id; sreg_data = v;
    @(negedge clk);
    sreg_we = 1'b0;
  endtask

  task automatic wr_desc(logic [3:0] idx, logic [63:0] v);
    desc_we = 1'b1; desc_idx = idx; desc_data = v;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic do_req(logic m, logic [2:0] s, logic [31:0] o,
                        output logic [31:0] a, output logic [2:0] f);
    req_valid = 1'b1; req_mode = m; req_seg = s; req_off = o;
    @(negedge clk);
    req_valid = 1'b0; sreg_we = 1'b0; desc_we = 1'b0;
    check("R10 response valid one cycle after accept", {31'd0, rsp_valid}, 32'd1);
    a = rsp_addr;
    f = rsp_fault;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] a, a0;
    logic [2:0]  f;
    repeat (3) @(negedge clk);
    check("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R12 req_ready after reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(1'b1, 3'd0, 32'h10, a, f);
    check("R12 null fault on cleared state", {29'd0, f}, 32'd2);

    wr_desc(4'd1, mk_desc(32'h1234_5678, 20'h00FFF, 1'b0, 1'b1));
    wr_desc(4'd2, mk_desc(32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1));
    wr_desc(4'd3, mk_desc(32'hFFFF_F000, 20'hFFFFF, 1'b0, 1'b1));
    wr_desc(4'd4, mk_desc(32'h0000_1000, 20'hFFFFF, 1'b0, 1'b0));
    wr_sreg(3'd0, 16'h000B);
    wr_sreg(3'd1, 16'h0010);
    wr_sreg(3'd2, 16'h0018);
    wr_sreg(3'd3, 16'h0020);
    wr_sreg(3'd4, 16'h0004);
    wr_sreg(3'd5, 16'h0080);
    wr_sreg(3'd6, 16'h1234);  // R2 ignored

    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i].mode, VECS[i].seg, VECS[i].off, a, f);
      n_chk++;
      if (a !== VECS[i].addr || f !== VECS[i].flt) begin
        n_fail++;
        $display("FAIL vector %0d R%0d: actual %h/%0d expected %h/%0d",
                 i, VECS[i].req, a, f, VECS[i].addr, VECS[i].flt);
      end
    end

    // R11 selector write in the same cycle as a request
    sreg_we = 1'b1; sreg_id = 3'd0; sreg_data = 16'h0010;
    do_req(1'b1, 3'd0, 32'h10, a, f);
    check("R11 old selector used", a, 32'h1234_5688);
    do_req(1'b1, 3'd0, 32'h10, a, f);
    check("R11 new selector next request", a, 32'h0000_0010);
    // R11 descriptor write in the same cycle as a request
    desc_we = 1'b1; desc_idx = 4'd2; desc_data = mk_desc(32'h0000_0100, 20'hFFFFF, 1'b1, 1'b1);
    do_req(1'b1, 3'd1, 32'h5, a, f);
    check("R11 old descriptor used", a, 32'h0000_0005);
    do_req(1'b1, 3'd1, 32'h5, a, f);
    check("R11 new descriptor next request", a, 32'h0000_0105);

    // R1 carry out of bit 19 dropped
    wr_sreg(3'd0, 16'hFFFF);
    do_req(1'b0, 3'd0, 32'h0000_FFFF, a, f);
    check("R1 20-bit wrap", a, 32'h0000_FFEF);

    // R8 granular limit: limit 1, bit55 -> eff 0x1FFF
    wr_desc(4'd5, mk_desc(32'h0, 20'h00001, 1'b1, 1'b1));
    wr_sreg(3'd0, 16'h0028);
    do_req(1'b1, 3'd0, 32'h1FFF, a, f);
    check("R8 granular at limit fault", {29'd0, f}, 32'd0);
    do_req(1'b1, 3'd0, 32'h2000, a, f);
    check("R8 granular past limit fault", {29'd0, f}, 32'd5);
    // R5 indicator wins over null and range
    wr_sreg(3'd0, 16'hFFFC);
    do_req(1'b1, 3'd0, 32'h0, a, f);
    check("R5 indicator priority", {29'd0, f}, 32'd1);

    // R10 back-pressure
    wr_sreg(3'd0, 16'h0010);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_mode = 1'b1; req_seg = 3'd0; req_off = 32'h40;
    @(negedge clk);
    check("R10 valid under back-pressure", {31'd0, rsp_valid}, 32'd1);
    check("R10 ready low while held", {31'd0, req_ready}, 32'd0);
    a0 = rsp_addr;
    check("R10 first address", a0, 32'h0000_0140);
    req_off = 32'h80;
    repeat (2) @(negedge clk);
    check("R10 address held", rsp_addr, 32'h0000_0140);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second request after release", rsp_addr, 32'h0000_0180);
    @(negedge clk);
    check("R10 valid drops when drained", {31'd0, rsp_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule